// File: doc/BRIEF.md
# Per-Lane Write-Leveling Delay Sweeper

This block aligns the output strobe of each byte lane to the memory clock. On a start request it sends a mode-register command that puts the memory into its write-leveling mode. It then steps every lane's strobe delay code upward from zero, one code at a time. At each code it reads back the memory's one-bit report of whether the strobe edge came before or after the clock rising edge.

Each lane settles on its own code: the first code at which the report turns from 0 to 1. Every lane then holds that code while the other lanes keep stepping. A lane that reaches the top code without such a transition is marked as failed. When no lane is still searching, a second mode-register command takes the memory out of leveling mode and a done flag is raised. The delay line and the memory's sampling circuit lie outside this block.

Top module: `wl_sweeper`

## Requirements
- R1: When `start_i` is high while the block is idle or done, the block drives `mr_valid_o` high for exactly one cycle, in the next cycle, with `mr_lvl_o` = 1. This is the command that enters leveling mode.
- R2: On entry, every lane's delay code is set to 0. The sweep is made of steps of SETTLE+VOTES cycles each. After each step, an unresolved lane's code rises by exactly 1.
- R3: The feedback value for a step is the majority of the VOTES samples taken in that step's last VOTES cycles. One inverted sample out of three does not change the result.
- R4: A lane locks at the first code whose vote is 1 when the vote at the code before it was 0. It then holds that code until the next start. A vote of 1 at code 0, or a run of 1s before any 0, does not lock the lane.
- R5: Lanes resolve independently. A locked or failed lane stops changing while the other lanes keep stepping.
- R6: A lane that does not lock at the top code (2^DLY_W−1) sets its `fail_o` bit and keeps the top code. A 0-to-1 transition that happens exactly at the top code locks the lane and does not fail it. Fail bits are cleared only when a new sweep starts.
- R7: In the cycle after the last lane resolves, `mr_valid_o` is high for one cycle with `mr_lvl_o` = 0, which exits leveling mode. After that, `done_o` stays high until the next start.
- R8: A high `start_i` during a sweep has no effect on any output.
- R9: While `rst_n` is low, all delay codes are 0 and `done_o`, `fail_o` and `mr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run a leveling sweep |
| fb_i | input | LANES | Per-lane strobe-versus-clock feedback from the memory |
| dly_o | output | LANES*DLY_W | Per-lane strobe delay codes, lane i at bits [i*DLY_W +: DLY_W] |
| mr_valid_o | output | 1 | One-cycle mode-register command strobe |
| mr_lvl_o | output | 1 | Leveling-mode value carried by the command (1 enter, 0 exit) |
| done_o | output | 1 | All lanes resolved and leveling mode exited |
| fail_o | output | LANES | Per-lane flag: no transition found |

## Verification
The enter command is due one cycle after `start_i` is sampled. The first step's result is due 1+SETTLE+VOTES cycles after that, and each later step's result follows SETTLE+VOTES cycles after the one before it. The exit command is due in the cycle after the final evaluation, and `done_o` one cycle later. The bench holds a behavioural model that waits out these same cycle counts and computes each vote from the noise-free lane skew. It compares codes, fail bits, done and the command pins in the middle of every clock period, so a result that arrives one cycle early or late is flagged. One lane gets one inverted sample in every group of three consecutive cycles, which tests the majority vote.

// File: rtl/wl_sweeper.sv
module wl_sweeper #(
  parameter int LANES  = 4,
  parameter int DLY_W  = 5,
  parameter int SETTLE = 4,
  parameter int VOTES  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LANES-1:0]       fb_i,
  output logic [LANES*DLY_W-1:0] dly_o,
  output logic                   mr_valid_o,
  output logic                   mr_lvl_o,
  output logic                   done_o,
  output logic [LANES-1:0]       fail_o
);

  localparam logic [DLY_W-1:0] TOP = '1;
  localparam int CMAX = (SETTLE > VOTES) ? SETTLE : VOTES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int VW   = $clog2(VOTES + 1);
  localparam int HALF = VOTES / 2;

  typedef enum logic [2:0] {S_IDLE, S_ENTER, S_WAIT, S_SAMP, S_EXIT, S_DONE} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [DLY_W-1:0]  code   [LANES];
  logic [VW-1:0]     ones   [LANES];
  logic [LANES-1:0]  seen0, locked, failed, vote, lock_now, fail_now;

  wire kick      = start_i && (st == S_IDLE || st == S_DONE);
  wire last_samp = (st == S_SAMP) && (cnt == CW'(VOTES - 1));
  wire all_res   = &(locked | failed | lock_now | fail_now);

  assign mr_valid_o = (st == S_ENTER) || (st == S_EXIT);
  assign mr_lvl_o   = (st == S_ENTER);
  assign done_o     = (st == S_DONE);
  assign fail_o     = failed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start_i) st <= S_ENTER;
        S_ENTER: begin
          st  <= S_WAIT;
          cnt <= '0;
        end
        S_WAIT: begin
          if (cnt == CW'(SETTLE - 1)) begin
            st  <= S_SAMP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SAMP: begin
          if (last_samp) begin
            st  <= all_res ? S_EXIT : S_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_EXIT:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [VW:0] tally;
    assign tally       = {1'b0, ones[i]} + (VW+1)'(fb_i[i]);
    assign vote[i]     = tally > (VW+1)'(HALF);
    assign lock_now[i] = !locked[i] && !failed[i] && vote[i] && seen0[i];
    assign fail_now[i] = !locked[i] && !failed[i] && !lock_now[i] && (code[i] == TOP);
    assign dly_o[i*DLY_W +: DLY_W] = code[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code[i]   <= '0;
        ones[i]   <= '0;
        seen0[i]  <= 1'b0;
        locked[i] <= 1'b0;
        failed[i] <= 1'b0;
      end else if (kick) begin
        code[i]   <= '0;
        ones[i]   <= '0;
        seen0[i]  <= 1'b0;
        locked[i] <= 1'b0;
        failed[i] <= 1'b0;
      end else if (last_samp) begin
        ones[i] <= '0;
        if (lock_now[i])      locked[i] <= 1'b1;
        else if (fail_now[i]) failed[i] <= 1'b1;
        else if (!locked[i] && !failed[i]) begin
          code[i]  <= code[i] + 1'b1;
          seen0[i] <= !vote[i];
        end
      end else if (st == S_SAMP) begin
        ones[i] <= tally[VW-1:0];
      end
    end

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (code[i] != $past(code[i])) |-> (code[i] == $past(code[i]) + 1'b1 || code[i] == '0)); // R2
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked[i] && !kick) |=> $stable(code[i])); // R4
    AST_FAIL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o[i] |-> (dly_o[i*DLY_W +: DLY_W] == TOP)); // R6
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fail_o[i]) |-> (mr_valid_o && mr_lvl_o)); // R6
  end

  AST_MR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid_o |=> !mr_valid_o); // R1
  AST_DONE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(mr_valid_o) && !$past(mr_lvl_o))); // R7
  AST_ENTER_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (done_o || (!mr_valid_o && st == S_IDLE))) |=> (mr_valid_o && mr_lvl_o)); // R1

endmodule

// File: tb/wl_sweeper_tb_top.sv
module wl_sweeper_tb_top;
  localparam int LANES = 4, W = 5, SETTLE = 4, VOTES = 3;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LANES-1:0] fb;
  logic [LANES*W-1:0] dly;
  logic mrv, mrl, done;
  logic [LANES-1:0] fail;

  int checks = 0, errors = 0, cyc = 0, mr_cnt = 0;
  int skew [LANES];
  int pre1 [LANES];
  int exp_code [LANES];
  logic [LANES-1:0] exp_fail = '0;
  logic exp_mrv = 1'b0, exp_lvl = 1'b0, exp_done = 1'b0;

  always #2.5 clk = ~clk;

  wl_sweeper #(.LANES(LANES), .DLY_W(W), .SETTLE(SETTLE), .VOTES(VOTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fb_i(fb), .dly_o(dly),
    .mr_valid_o(mrv), .mr_lvl_o(mrl), .done_o(done), .fail_o(fail));

  function automatic logic clean(int i, int c);
    return (c >= skew[i]) || (c < pre1[i]);
  endfunction

  always_comb
    for (int i = 0; i < LANES; i++)
      fb[i] = clean(i, int'(dly[i*W +: W])) ^ (i == 0 && (cyc % 3) == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mrv) mr_cnt <= mr_cnt + 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic run_model();
    bit all_res;
    bit seen0 [LANES];
    bit res [LANES];
    #1;
    exp_done = 1'b0; exp_fail = '0; exp_mrv = 1'b1; exp_lvl = 1'b1;
    for (int i = 0; i < LANES; i++) begin exp_code[i] = 0; seen0[i] = 0; res[i] = 0; end
    @(posedge clk); #1;
    exp_mrv = 1'b0; exp_lvl = 1'b0;
    do begin
      repeat (SETTLE + VOTES) @(posedge clk);
      #1;
      all_res = 1;
      for (int i = 0; i < LANES; i++) begin
        if (!res[i]) begin
          bit v;
          v = clean(i, exp_code[i]);
          if (v && seen0[i]) res[i] = 1;
          else if (exp_code[i] == TOP) begin res[i] = 1; exp_fail[i] = 1'b1; end
          else begin exp_code[i]++; seen0[i] = !v; end
        end
        all_res &= res[i];
      end
    end while (!all_res);
    exp_mrv = 1'b1;
    @(posedge clk); #1;
    exp_mrv = 1'b0; exp_done = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) exp_code[i] = 0;
    forever begin
      @(posedge clk);
      if (rst_n && start) run_model();
    end
  end

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < LANES; i++) begin
      chk("R2/R4/R5 dly", int'(dly[i*W +: W]), exp_code[i]);
      chk("R6 fail", int'(fail[i]), int'(exp_fail[i]));
    end
    chk("R1/R7 mr_valid", int'(mrv), int'(exp_mrv));
    if (mrv) chk("R1/R7 mr_lvl", int'(mrl), int'(exp_lvl));
    chk("R7 done", int'(done), int'(exp_done));
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    skew = '{7, 3, 10, 20};
    pre1 = '{0, 0, 4, 0};
    repeat (3) @(negedge clk);
    chk("R9 reset dly", int'(dly), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset fail", int'(fail), 0);
    chk("R9 reset mr_valid", int'(mrv), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();  // R8: ignored mid-sweep
    wait_done();
    chk("R3 lane0 noisy lock", int'(dly[0 +: W]), 7);
    chk("R5 lane1 lock", int'(dly[W +: W]), 3);
    chk("R4 lane2 needs 0 first", int'(dly[2*W +: W]), 10);
    chk("R5 lane3 lock", int'(dly[3*W +: W]), 20);
    chk("R6 no fail run1", int'(fail), 0);
    chk("R8 two commands run1", mr_cnt, 2);

    skew = '{1, 31, 40, 0};
    pre1 = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    chk("R7 done held", int'(done), 1);
    pulse_start();
    wait_done();
    chk("R4 lane0 lock at 1", int'(dly[0 +: W]), 1);
    chk("R6 lane1 lock at top", int'(dly[W +: W]), TOP);
    chk("R6 lane2 fail code", int'(dly[2*W +: W]), TOP);
    chk("R6 fail bits", int'(fail), 4'b1100);
    chk("R1/R7 commands run2", mr_cnt, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule